// File: doc/BRIEF.md
# Dual-Mode DMA Status Register

This block holds the DMA status word of a bus-mastering SCSI host adapter. The DMA engine sends single-cycle event pulses for error, abort, transfer done, block transfer complete and one auxiliary event. The status word latches each pulse into a sticky flag. The word also shows the live interrupt level of the SCSI core, which is not stored. Software reaches the block through a simple register port that decodes two addresses: one for the status word and one for a control word.

A single mode bit in the control word selects how the mode-governed flags (bits 1, 2, 3 and 6) are cleared. With the mode bit at 1, reads do not disturb the flags, and each flag clears only when software writes a one to its position. With the mode bit at 0, a read returns the flags and clears them in the same step, and writes to those positions do nothing. The mode can be changed at run time. An event pulse always wins over a clear in the same cycle, so no event is lost. An interrupt output summarises the error, abort and done flags together with the live SCSI interrupt.

Top module: `dmaStatusReg`

## Requirements
- R1: After reset, every status flag and the mode bit are 0, reads of both addresses return 0, and `irqOut` follows only `scsiIntLive`.
- R2: The mode is bit 24 of the control word, and a control read returns it at bit 24 with all other bits 0. Writing a control word with only bit 12 set leaves the mode at 0, so clear-on-read stays in force.
- R3: With the mode at 1, reading the status word leaves bits 1 (error), 2 (abort), 3 (done) and 6 (auxiliary) unchanged.
- R4: With the mode at 1, a status write clears exactly those of bits 1, 2, 3 and 6 where the write data holds a 1. Zeros leave their bits untouched, so writing 8'b0000_0010 clears only bit 1.
- R5: With the mode at 0, a status read returns the current bits 1, 2, 3 and 6 and then clears them.
- R6: With the mode at 0, a status write has no effect on bits 1, 2, 3 and 6.
- R7: Status bit 4 is not stored. It reads as the level of `scsiIntLive` in the cycle the read is sampled.
- R8: Status bit 5 is set by `evtBlkDone` and is cleared only by writing a 1 to bit 5, in either mode. A read never clears it.
- R9: An event pulse in the same cycle as a clear of its bit, whether by read or by write, leaves the bit at 1.
- R10: Read data appears on `busRdata` in the cycle after the read strobe and holds the pre-clear value. In cycles with no read, `busRdata` is 0.
- R11: `irqOut` is high while any of status bits 1, 2 or 3 is set, or while `scsiIntLive` is high. Bits 5 and 6 do not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address (status or control) |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data, one cycle after the strobe |
| evtError | input | 1 | DMA error event pulse (bit 1) |
| evtAbort | input | 1 | DMA abort event pulse (bit 2) |
| evtDone | input | 1 | Transfer done event pulse (bit 3) |
| evtBlkDone | input | 1 | Block transfer complete pulse (bit 5) |
| evtAux | input | 1 | Auxiliary event pulse (bit 6) |
| scsiIntLive | input | 1 | Live SCSI core interrupt level (bit 4) |
| irqOut | output | 1 | Summary interrupt |

## Verification
The bench writes a control word with only bit 12 set and confirms that clearing still happens on read. A design that decoded the mode at the wrong bit would keep the flags and fail this check. In both modes the bench writes a mix of ones and zeros and reads the word back. A design with the mode polarity inverted would clear on read when write-one-to-clear was selected, or the reverse, and would lose flags or leave stale ones in place. The bench also fires events in the same cycle as a write clear and as a read clear. A design that let the clear win would drop the event, and a later read would come back 0. Finally, the bench checks that bit 4 shows the live line and is not stored, and that bit 5 survives reads, which catches designs that latch the interrupt or clear block-complete on read.

// File: rtl/dmaStatPkg.sv
package dmaStatPkg;

  // strobes from the address decode to the register datapath
  typedef struct packed {
    logic statRd;
    logic statWr;
    logic ctrlRd;
    logic ctrlWr;
  } regStrobes_t;

  localparam int BIT_ERR  = 1;
  localparam int BIT_ABT  = 2;
  localparam int BIT_DONE = 3;
  localparam int BIT_LIVE = 4;
  localparam int BIT_BLK  = 5;
  localparam int BIT_AUX  = 6;
  localparam int STAT_W   = 8;

  // flags whose clearing follows the mode bit
  localparam logic [STAT_W-1:0] GOV_MASK =
    STAT_W'((1 << BIT_ERR) | (1 << BIT_ABT) | (1 << BIT_DONE) | (1 << BIT_AUX));
  // flags that feed the summary interrupt
  localparam logic [STAT_W-1:0] IRQ_MASK =
    STAT_W'((1 << BIT_ERR) | (1 << BIT_ABT) | (1 << BIT_DONE));

endpackage

// File: rtl/dmaStatCtl.sv
module dmaStatCtl
  import dmaStatPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
  input  logic              busRe,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobes_t       stb
);

  logic hitStat;
  logic hitCtrl;

  assign hitStat = (busAddr == STAT_ADDR);
  assign hitCtrl = (busAddr == CTRL_ADDR);

  always_comb begin
    stb.statRd = busRe & hitStat;
    stb.statWr = busWe & hitStat;
    stb.ctrlRd = busRe & hitCtrl;
    stb.ctrlWr = busWe & hitCtrl;
  end

endmodule

// File: rtl/dmaStatDp.sv
module dmaStatDp
  import dmaStatPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MODE_BIT = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0] evtVec,
  input  logic              scsiIntLive,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic              modeW1c;
  logic [STAT_W-1:0] sticky;
  logic [STAT_W-1:0] statByte;
  logic              clrOnRead;
  logic              w1cWrite;
  logic              unusedInputs;

  assign clrOnRead    = stb.statRd & ~modeW1c;
  assign w1cWrite     = stb.statWr & modeW1c;
  assign unusedInputs = ^{wdata, evtVec};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           modeW1c <= 1'b0;
    else if (stb.ctrlWr) modeW1c <= wdata[MODE_BIT];
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (GOV_MASK[i]) begin : g_gov
      logic q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= 1'b0;
        else       q <= evtVec[i] | (q & ~(clrOnRead | (w1cWrite & wdata[i])));
      end
      assign sticky[i] = q;
    end else if (i == BIT_BLK) begin : g_w1c
      logic q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= 1'b0;
        else       q <= evtVec[i] | (q & ~(stb.statWr & wdata[i]));
      end
      assign sticky[i] = q;
    end else begin : g_none
      assign sticky[i] = 1'b0;
    end
  end

  always_comb begin
    statByte           = sticky;
    statByte[BIT_LIVE] = scsiIntLive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdata <= '0;
    else if (stb.statRd) rdata <= DATA_W'(statByte);
    else if (stb.ctrlRd) rdata <= DATA_W'(modeW1c) << MODE_BIT;
    else                 rdata <= '0;
  end

  assign irq = (|(sticky & IRQ_MASK)) | scsiIntLive;

endmodule

// File: rtl/dmaStatusReg.sv
module dmaStatusReg
  import dmaStatPkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int MODE_BIT = 24,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              evtError,
  input  logic              evtAbort,
  input  logic              evtDone,
  input  logic              evtBlkDone,
  input  logic              evtAux,
  input  logic              scsiIntLive,
  output logic              irqOut
);

  regStrobes_t       stb;
  logic [STAT_W-1:0] evtVec;

  always_comb begin
    evtVec           = '0;
    evtVec[BIT_ERR]  = evtError;
    evtVec[BIT_ABT]  = evtAbort;
    evtVec[BIT_DONE] = evtDone;
    evtVec[BIT_BLK]  = evtBlkDone;
    evtVec[BIT_AUX]  = evtAux;
  end

  dmaStatCtl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) uCtl (
    .busRe(busRe), .busWe(busWe), .busAddr(busAddr), .stb(stb)
  );

  dmaStatDp #(
    .DATA_W(DATA_W), .MODE_BIT(MODE_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .evtVec(evtVec),
    .scsiIntLive(scsiIntLive), .rdata(busRdata), .irq(irqOut)
  );

endmodule

// File: rtl/dmaStatusChk.sv
module dmaStatusChk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int MODE_BIT = 24,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              evtError,
  input logic              evtAbort,
  input logic              evtDone,
  input logic              evtAux,
  input logic              scsiIntLive,
  input logic              irqOut
);

  logic modeSh;
  logic statRd;
  logic anyEvt;

  assign statRd = busRe && (busAddr == STAT_ADDR);
  assign anyEvt = evtError || evtAbort || evtDone || evtAux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeSh <= 1'b0;
    else if (busWe && busAddr == CTRL_ADDR) modeSh <= busWdata[MODE_BIT];
  end

  // R11
  live_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    scsiIntLive |-> irqOut);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtError || evtAbort || evtDone) |=> irqOut);

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> busRdata == '0);

  // R7
  live_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> busRdata[4] == $past(scsiIntLive));

  // R2
  ctrl_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == CTRL_ADDR) |=>
      busRdata == ($past(modeSh) ? (DATA_W'(1) << MODE_BIT) : '0));

  // R5
  cor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && !modeSh && !anyEvt && !busWe) ##1 statRd |=>
      (busRdata[3:1] == 3'b000) && !busRdata[6]);

  // R3
  keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && modeSh && !anyEvt && !busWe) ##1 (statRd && !anyEvt && !busWe) |=>
      (busRdata[3:1] == $past(busRdata[3:1])) && (busRdata[6] == $past(busRdata[6])));

endmodule

bind dmaStatusReg dmaStatusChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_BIT(MODE_BIT),
  .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
  .busWdata(busWdata), .busRdata(busRdata), .evtError(evtError),
  .evtAbort(evtAbort), .evtDone(evtDone), .evtAux(evtAux),
  .scsiIntLive(scsiIntLive), .irqOut(irqOut)
);

// File: tb/tb_dmaStatusReg.sv
`timescale 1ns/1ps
module tb_dmaStatusReg;

  localparam logic [3:0] STAT = 4'd0;
  localparam logic [3:0] CTRL = 4'd1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evtError = 1'b0, evtAbort = 1'b0, evtDone = 1'b0;
  logic        evtBlkDone = 1'b0, evtAux = 1'b0;
  logic        scsiIntLive = 1'b0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic pend = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  dmaStatusReg dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .evtError(evtError),
    .evtAbort(evtAbort), .evtDone(evtDone), .evtBlkDone(evtBlkDone),
    .evtAux(evtAux), .scsiIntLive(scsiIntLive), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: a read strobed at one edge yields data checked at the next negedge
  always @(posedge clk) pend <= busRe;
  always @(negedge clk) begin
    if (pend) begin
      if (expQ.size() == 0) chk("R10 unexpected read", busRdata, '0);
      else chk(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  // driver: one bus cycle, events mapped by status bit position
  task automatic cyc(logic we, logic re, logic [3:0] addr, logic [31:0] wd,
                     logic [7:0] evt, logic [31:0] exp, string tag);
    busWe = we; busRe = re; busAddr = addr; busWdata = wd;
    evtError = evt[1]; evtAbort = evt[2]; evtDone = evt[3];
    evtBlkDone = evt[5]; evtAux = evt[6];
    if (re) begin expQ.push_back(exp); tagQ.push_back(tag); end
    @(negedge clk);
    busWe = 0; busRe = 0; busWdata = '0;
    evtError = 0; evtAbort = 0; evtDone = 0; evtBlkDone = 0; evtAux = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] e, string t); cyc(0, 1, a, '0, '0, e, t); endtask
  task automatic wr(logic [3:0] a, logic [31:0] d); cyc(1, 0, a, d, '0, '0, ""); endtask
  task automatic ev(logic [7:0] m); cyc(0, 0, STAT, '0, m, '0, ""); endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {31'b0, irqOut}, 32'd0);
    rd(STAT, 32'h0, "R1 status after reset");
    rd(CTRL, 32'h0, "R1 control after reset");
    ev('0);
    chk("R10 idle read data", busRdata, 32'h0);

    // live interrupt bit
    scsiIntLive = 1'b1;
    rd(STAT, 32'h10, "R7 live bit visible");
    chk("R11 irq from live line", {31'b0, irqOut}, 32'd1);
    scsiIntLive = 1'b0;
    ev('0);
    chk("R11 irq drops with live line", {31'b0, irqOut}, 32'd0);
    rd(STAT, 32'h0, "R7 live bit not stored");

    // mode 0: clear on read, writes ignored
    ev(8'h0A);
    chk("R11 irq from sticky flags", {31'b0, irqOut}, 32'd1);
    wr(STAT, 32'h4E);
    rd(STAT, 32'h0A, "R6 write ignored in mode 0");
    rd(STAT, 32'h0, "R5 cleared by previous read");
    chk("R5 irq after clear on read", {31'b0, irqOut}, 32'd0);

    // block complete bit
    ev(8'h20);
    chk("R11 block bit raises no irq", {31'b0, irqOut}, 32'd0);
    rd(STAT, 32'h20, "R8 block bit set");
    rd(STAT, 32'h20, "R8 block bit survives read");
    wr(STAT, 32'h20);
    rd(STAT, 32'h0, "R8 block bit write one clear");

    // wrong mode position
    wr(CTRL, 32'h0000_1000);
    rd(CTRL, 32'h0, "R2 bit 12 ignored");
    ev(8'h04);
    rd(STAT, 32'h04, "R2 abort read");
    rd(STAT, 32'h0, "R2 still clear on read");

    // mode 1
    wr(CTRL, 32'h0100_0000);
    rd(CTRL, 32'h0100_0000, "R2 mode at bit 24");
    ev(8'h4E);
    rd(STAT, 32'h4E, "R3 first read");
    rd(STAT, 32'h4E, "R3 read keeps flags");
    wr(STAT, 32'h02);
    rd(STAT, 32'h4C, "R4 clears only bit 1");
    wr(STAT, 32'h40);
    rd(STAT, 32'h0C, "R4 clears bit 6");
    wr(STAT, 32'h0C);
    rd(STAT, 32'h0, "R4 clears bits 3 and 2");
    chk("R4 irq after write clear", {31'b0, irqOut}, 32'd0);

    // set wins over write clear
    ev(8'h08);
    cyc(1, 0, STAT, 32'h08, 8'h08, '0, "");
    rd(STAT, 32'h08, "R9 event beats write clear");
    ev(8'h20);
    rd(STAT, 32'h28, "R8 block bit in mode 1");
    wr(STAT, 32'h20);
    rd(STAT, 32'h08, "R8 block bit cleared in mode 1");

    // set wins over read clear
    wr(CTRL, 32'h0);
    cyc(0, 1, STAT, '0, 8'h02, 32'h08, "R9 read with event returns old value");
    rd(STAT, 32'h02, "R9 event beats read clear");
    rd(STAT, 32'h0, "R5 clear on read after mode change");
    ev('0);
    ev('0);
    chk("R10 all reads answered", expQ.size(), 32'd0);
    finishRun();
  end

endmodule